// File: doc/BRIEF.md
# Sticky Alarm Status Register

This block holds the 8-bit status byte of a temperature monitor. Five fault inputs come from the comparison logic, each a level that is high for as long as its condition holds. They are local high limit, local low limit, remote high limit, remote low limit and remote sensor open circuit. Each fault sets a sticky flag that stays set after the condition goes away. A read strobe returns the byte and clears every flag whose condition has gone. A flag whose condition is still present stays set, so a persistent fault cannot be read away. The busy bit is not stored. It reports the converter's busy input as it is in the read cycle.

A read is a one-cycle pulse on the read strobe. The byte appears on the read data output after the next clock edge and holds there until the next read. The returned byte shows the flags as they stood before that read cleared them. If a fault arrives in the same cycle as the read, the set wins over the clear. That fault is missing from the current byte and shows up in the next one.

Top module: `alarm_status_reg`

## Requirements
- R1: After a synchronous active-low reset, every sticky flag is zero and the read data output is 0x00, so a first read with no fault present returns 0x00.
- R2: Bit positions of the returned byte: fault input bit 4 (local high) maps to byte bit 6, input bit 3 (local low) to bit 5, input bit 2 (remote high) to bit 4, input bit 1 (remote low) to bit 3, and input bit 0 (open circuit) to bit 2.
- R3: Byte bits 1 and 0 always read 0.
- R4: A flag set by a fault condition stays set after the condition drops, until a read or a reset.
- R5: Every read cycle loads the read data output at the next clock edge with the flags as they stood before that read's clear. Between reads the output holds its value.
- R6: A read clears each flag whose fault input is low in the read cycle, so a second read after the fault has gone returns that bit as 0.
- R7: A flag whose fault input is high in a read cycle is set after that cycle, whether it was set before or arrives in that same cycle. The set wins over the clear, and the event shows in the next read.
- R8: Byte bit 7 equals the busy input in the read cycle and is not latched. A later read with busy low returns bit 7 as 0.
- R9: Asserting reset at any time clears all sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_busy_i | input | 1 | Converter busy level, live |
| fault_lvl_i | input | 5 | Fault condition levels {local hi, local lo, remote hi, remote lo, open} |
| rd_stb_i | input | 1 | One-cycle read strobe for the status byte |
| rd_data_o | output | 8 | Status byte captured on the last read |

## Verification
A flag cell with wrong internal state shows up at the ports only on a later read. The next read byte will carry the wrong bit. A flag that wrongly stays set also shows in the read after that. So any error in a flag appears within two reads of its cause. Collisions between a read and a fault are the case to watch. A lost set appears one read later as a missing bit, and a clear that fails to take effect appears as a bit that survives one read too many. A latched busy bit shows as bit 7 set on a read taken while busy is low.

// File: rtl/alarm_status_pkg.sv
// Package: shared widths and byte layout of the alarm status register.
// Assumes the fault vector is ordered with the highest byte position first.
package alarm_status_pkg;
    localparam int NUM_FAULTS = 5;
    localparam int BYTE_W     = 8;
    localparam int BUSY_POS   = 7;
    localparam int FLAG_LSB   = 2;
    localparam int RSVD_W     = FLAG_LSB;

    typedef logic [NUM_FAULTS-1:0] fault_vec_t;
    typedef logic [BYTE_W-1:0]     status_byte_t;

    // Assemble the status byte from the live busy bit and the sticky flags.
    function automatic status_byte_t pack_status(input logic busy, input fault_vec_t flags);
        status_byte_t b;
        b = '0;
        b[BUSY_POS] = busy;
        b[FLAG_LSB +: NUM_FAULTS] = flags;
        return b;
    endfunction
endpackage

// File: rtl/sticky_flag_cell.sv
// Module: sticky_flag_cell
// One sticky alarm flag. A high fault level sets it. A read clears it only
// when the fault level is low in that cycle, so set wins over clear.
// Assumes rd_clr is a single-cycle strobe synchronous to clk.
module sticky_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_lvl,
    input  logic rd_clr,
    output logic flag_q
);
    // Flag register: set by the fault, cleared by a read, reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (fault_lvl)
            flag_q <= 1'b1;
        else if (rd_clr)
            flag_q <= 1'b0;
    end

    // R4: without a read, a set flag stays set
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !rd_clr) |=> flag_q);
    // R7: a present fault always leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fault_lvl |=> flag_q);
    // R6: a read with the fault gone clears the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !fault_lvl) |=> !flag_q);
endmodule

// File: rtl/status_read_port.sv
// Module: status_read_port
// Captures the status byte on a read strobe and holds it until the next one.
// Assumes the flags presented are the values before this cycle's clear.
module status_read_port
    import alarm_status_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_stb,
    input  logic         busy,
    input  fault_vec_t   flags,
    output status_byte_t rd_data
);
    // Read data register: load on a strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_stb)
            rd_data <= pack_status(busy, flags);
    end

    // R5: the byte carries the pre-clear flags of the read cycle
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data[FLAG_LSB +: NUM_FAULTS] == $past(flags)));
    // R5: output holds between reads
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    // R8: bit 7 follows the live busy input of the read cycle
    a_r8_busy_live: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data[BUSY_POS] == $past(busy)));
endmodule

// File: rtl/alarm_status_reg.sv
// Module: alarm_status_reg (top)
// Status byte with sticky alarm flags, clear-on-read and a live busy bit.
// Assumes fault inputs are levels already synchronous to clk.
module alarm_status_reg
    import alarm_status_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  conv_busy_i,
    input  logic [NUM_FAULTS-1:0] fault_lvl_i,
    input  logic                  rd_stb_i,
    output logic [BYTE_W-1:0]     rd_data_o
);
    fault_vec_t flags;

    // One sticky cell per fault input.
    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_flag
        sticky_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .fault_lvl (fault_lvl_i[g]),
            .rd_clr    (rd_stb_i),
            .flag_q    (flags[g])
        );
    end

    status_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb_i),
        .busy    (conv_busy_i),
        .flags   (flags),
        .rd_data (rd_data_o)
    );

    // R9: the cycle after reset, no flag is set
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));
endmodule

// File: tb/test_alarm_status_reg.sv
// Bench for alarm_status_reg: a vector table walked by one loop, then
// directed reset tests.
module test_alarm_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic [4:0] fault = '0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    alarm_status_reg i_alarm_status_reg (
        .clk(clk), .rst_n(rst_n), .conv_busy_i(busy),
        .fault_lvl_i(fault), .rd_stb_i(rd), .rd_data_o(rdata)
    );

    // Entry: {rd, busy, fault[4:0], chk, expected byte}
    localparam int NV = 19;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h00},  // R1 first read clean
        {1'b0, 1'b0, 5'b10000, 1'b1, 8'h00},  // R5 hold between reads
        {1'b0, 1'b0, 5'b00000, 1'b0, 8'h00},
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h40},  // R4 R2 local high sticky, bit6
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h00},  // R6 cleared
        {1'b0, 1'b0, 5'b00001, 1'b0, 8'h00},
        {1'b1, 1'b0, 5'b00001, 1'b1, 8'h04},  // R2 open bit2
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h04},  // R7 still present, kept
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h00},  // R6
        {1'b1, 1'b0, 5'b00100, 1'b1, 8'h00},  // R5 pre-clear value in collision
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h10},  // R7 colliding event not lost
        {1'b1, 1'b1, 5'b00000, 1'b1, 8'h80},  // R8 busy live
        {1'b0, 1'b0, 5'b00000, 1'b1, 8'h80},  // R5 hold
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h00},  // R8 not latched
        {1'b0, 1'b0, 5'b11111, 1'b0, 8'h00},
        {1'b1, 1'b1, 5'b00000, 1'b1, 8'hFC},  // R2 R3 all set, low bits zero
        {1'b1, 1'b0, 5'b01010, 1'b1, 8'h00},  // R7 collision set
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h28},  // R2 local low bit5, remote low bit3
        {1'b1, 1'b0, 5'b00000, 1'b1, 8'h00}   // R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", rdata, 8'h00);
        for (int i = 0; i < NV; i++) begin
            rd    = VEC[i][15];
            busy  = VEC[i][14];
            fault = VEC[i][13:9];
            @(negedge clk);
            if (VEC[i][8]) check($sformatf("vector %0d (R2/R4-R8)", i), rdata, VEC[i][7:0]);
            check("R3", {6'b0, rdata[1:0]}, 8'h00);
        end
        // R9: reset with flags set, then read returns zero
        rd = 1'b0; busy = 1'b0; fault = 5'b10101;
        @(negedge clk);
        fault = '0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset output", rdata, 8'h00);
        rst_n = 1'b1;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R9 flags cleared", rdata, 8'h00);
        // R4: flag survives many idle cycles
        fault = 5'b00010;
        @(negedge clk);
        fault = '0;
        repeat (20) @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R4 long hold", rdata, 8'h08);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule